// File: doc/BRIEF.md
# Translation Cache with Global Entries

This block holds a small, fully associative set of finished virtual-to-physical page translations and sits in front of a page walker. Each cycle a lookup presents a virtual page number and an access type. In the same cycle, with no register in the path, the block answers with a hit flag, the physical frame, the write and user permissions and the page size. When a lookup misses, the walker fetches the page entry from memory and hands the raw 32-bit entry to the fill port, which installs it.

Two maintenance operations keep the cache coherent with the tables in memory. A write to the directory base register drops every cached translation except those whose global flag is set. A single-page invalidate drops only the translations that cover one given virtual page, and this includes global ones. A cached entry maps either a small 4 KB page or a large 4 MB page. A fill first clears any cached translation it overlaps, so that no address can match two entries. It then uses the lowest free slot, and when no slot is free it evicts under a round-robin pointer.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, and every lookup returns lk_hit = 0.
- R2: A fill decodes the raw page entry as follows: frame in bits 31:12, write permission in bit 1, user permission in bit 2, dirty flag in bit 6, large-page flag in bit 7, global flag in bit 8. From the next cycle on, a read lookup of the filled page returns lk_hit = 1 with that frame, lk_rw and lk_usr.
- R3: A small-page entry matches only when all 20 bits of the page number are equal. A large-page entry matches on page-number bits 19:10 alone and returns the frame {stored frame[19:10], lookup page number[9:0]} with lk_big = 1.
- R4: A write lookup (lk_wr = 1) that matches an entry whose dirty flag is clear returns lk_hit = 0. The same entry hits on a read lookup, and an entry with its dirty flag set hits on a write lookup.
- R5: A base-register write (base_wr) clears every entry whose global flag is clear. Entries whose global flag is set keep their contents.
- R6: A single-page invalidate (inv_en with inv_vpn) clears every entry that matches inv_vpn under that entry's own page size, whether or not the entry is global. All other entries keep their contents.
- R7: When every slot is occupied, a fill replaces the slot under a round-robin pointer. The pointer is 0 after reset, advances by one only on such a fill, and wraps from the last slot to 0. Otherwise a fill takes the lowest-numbered free slot.
- R8: A fill first clears every valid entry that overlaps the new page. Two pages overlap when their upper 10 page-number bits are equal and either page is large, or when both are small and all 20 bits are equal. The cleared slots count as free.
- R9: When a base-register write or an invalidate arrives in the same cycle as a fill, the maintenance is applied first and the fill is written afterwards, so the new entry is present in the next cycle.
- R10: At most one entry matches any lookup page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_wr | input | 1 | Lookup is a write access |
| lk_hit | output | 1 | Lookup found a usable translation |
| lk_pfn | output | 20 | Physical frame number of the hit |
| lk_rw | output | 1 | Write permission of the hit |
| lk_usr | output | 1 | User permission of the hit |
| lk_big | output | 1 | Hit entry maps a large page |
| fill_en | input | 1 | Install a walked translation |
| fill_vpn | input | 20 | Virtual page number being installed |
| fill_pte | input | 32 | Raw page entry from the walker |
| base_wr | input | 1 | Directory base register written |
| inv_en | input | 1 | Invalidate one page |
| inv_vpn | input | 20 | Page number to invalidate |

## Verification
The assertions check the rules that hold on every cycle, whatever the stimulus. Lookups never see two matches. The round-robin pointer stays in range and moves only on a fill into a full cache. Each slot clears after a flush or invalidate that targets it, and a global slot stays set through a flush. After a flush with no fill, no non-global entry is left. Some results depend on the sequence of operations, such as which entry a round-robin eviction removes, how a large fill replaces a small entry beneath it, and the dirty-miss rule on write lookups. Only the bench's scenarios show these, by comparing each lookup against a model kept in the bench.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;
   localparam int VPN_W = 20;
   localparam int PFN_W = 20;
   localparam int BIG_W = 10;
   localparam int PTE_W = 32;
   localparam int LOW_W = VPN_W - BIG_W;

   // positions of fields inside the raw page entry delivered by the walker
   localparam int PB_RW    = 1;
   localparam int PB_USR   = 2;
   localparam int PB_DIRTY = 6;
   localparam int PB_BIG   = 7;
   localparam int PB_GLB   = 8;
   localparam int PB_FRAME = 12;

   typedef struct packed {
      logic             valid;
      logic [VPN_W-1:0] vpn;
      logic [PFN_W-1:0] pfn;
      logic             rw;
      logic             usr;
      logic             dirty;
      logic             glob;
      logic             big;
   } xlat_ent_t;

   function automatic xlat_ent_t decode_pte(input logic [VPN_W-1:0] vpn,
                                            input logic [PTE_W-1:0] pte);
      xlat_ent_t e;
      e.valid = 1'b1;
      e.vpn   = vpn;
      e.pfn   = pte[PB_FRAME +: PFN_W];
      e.rw    = pte[PB_RW];
      e.usr   = pte[PB_USR];
      e.dirty = pte[PB_DIRTY];
      e.glob  = pte[PB_GLB];
      e.big   = pte[PB_BIG];
      return e;
   endfunction

   function automatic logic upper_eq(input logic [VPN_W-1:0] a,
                                     input logic [VPN_W-1:0] b);
      return a[VPN_W-1 -: BIG_W] == b[VPN_W-1 -: BIG_W];
   endfunction

   // does entry e translate page number v
   function automatic logic covers(input xlat_ent_t e, input logic [VPN_W-1:0] v);
      return e.valid && (e.big ? upper_eq(e.vpn, v) : (e.vpn == v));
   endfunction

   // would a new page (v, big) overlap entry e
   function automatic logic overlaps(input xlat_ent_t e, input logic [VPN_W-1:0] v,
                                     input logic big);
      return e.valid && ((e.big || big) ? upper_eq(e.vpn, v) : (e.vpn == v));
   endfunction
endpackage

// File: rtl/xlat_entry.sv
module xlat_entry
   import xlat_cache_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VPN_W-1:0] lk_vpn,
   input  logic             flush,
   input  logic             inv_en,
   input  logic [VPN_W-1:0] inv_vpn,
   input  logic             fill_en,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic             fill_big,
   input  logic             wr_sel,
   input  xlat_ent_t        wr_ent,
   output xlat_ent_t        ent,
   output logic             lk_match,
   output logic             busy
);
   xlat_ent_t ent_q;
   logic      inv_hit;
   logic      ovl_hit;
   logic      flush_hit;

   assign ent       = ent_q;
   assign lk_match  = covers(ent_q, lk_vpn);
   assign inv_hit   = inv_en && covers(ent_q, inv_vpn);
   assign ovl_hit   = fill_en && overlaps(ent_q, fill_vpn, fill_big);
   assign flush_hit = flush && ent_q.valid && !ent_q.glob;
   // occupancy once maintenance and overlap clearing are applied
   assign busy      = ent_q.valid && !inv_hit && !ovl_hit && !flush_hit;

   always_ff @(posedge clk) begin
      if (!rst_n)      ent_q       <= '0;
      else if (wr_sel) ent_q       <= wr_ent;
      else             ent_q.valid <= busy;
   end

   // R5: a global entry is kept across a base-register write
   a_r5_global_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_q.valid && ent_q.glob && flush && !inv_hit && !ovl_hit && !wr_sel)
      |=> (ent_q.valid && ent_q.glob));
   // R5: a local entry is dropped by a base-register write
   a_r5_local_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !ent_q.glob && !wr_sel) |=> !ent_q.valid);
   // R6: a targeted invalidate drops the entry
   a_r6_inv_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_hit && !wr_sel) |=> !ent_q.valid);
   // R6: without maintenance or writes the entry holds its contents
   a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && !inv_en && !fill_en) |=> $stable(ent_q));
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fill_en,
   input  logic [N-1:0] busy,
   output logic [N-1:0] sel
);
   localparam int PW = (N > 1) ? $clog2(N) : 1;
   localparam logic [PW-1:0] LAST = PW'(N - 1);

   logic [PW-1:0] rr_q;
   logic [N-1:0]  first_free;
   logic          any_free;
   logic          adv;

   assign any_free = ~&busy;
   assign adv      = fill_en && !any_free;

   always_comb begin
      first_free = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!busy[i]) begin
            first_free    = '0;
            first_free[i] = 1'b1;
         end
      end
   end

   always_comb begin
      sel = '0;
      if (fill_en) begin
         if (any_free) sel = first_free;
         else          sel[rr_q] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   rr_q <= '0;
      else if (adv) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
   end

   a_r7_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
      rr_q <= LAST);
   a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(rr_q));
   a_r7_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |-> $onehot(sel));
   a_r7_no_sel_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !fill_en |-> (sel == '0));
endmodule

// File: rtl/xlat_hitmux.sv
module xlat_hitmux
   import xlat_cache_pkg::*;
#(
   parameter int N = 8
) (
   input  logic [N-1:0]     match,
   input  xlat_ent_t        ents [N],
   input  logic [VPN_W-1:0] lk_vpn,
   input  logic             lk_wr,
   output logic             lk_hit,
   output logic [PFN_W-1:0] lk_pfn,
   output logic             lk_rw,
   output logic             lk_usr,
   output logic             lk_big
);
   xlat_ent_t pick;

   always_comb begin
      pick = '0;
      for (int i = 0; i < N; i++) begin
         if (match[i]) pick = pick | ents[i];
      end
   end

   assign lk_hit = (|match) && !(lk_wr && !pick.dirty);
   assign lk_pfn = pick.big ? {pick.pfn[PFN_W-1 -: BIG_W], lk_vpn[LOW_W-1:0]} : pick.pfn;
   assign lk_rw  = pick.rw;
   assign lk_usr = pick.usr;
   assign lk_big = pick.big;
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlat_cache_pkg::*;
#(
   parameter int ENTRIES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [19:0]      lk_vpn,
   input  logic             lk_wr,
   output logic             lk_hit,
   output logic [19:0]      lk_pfn,
   output logic             lk_rw,
   output logic             lk_usr,
   output logic             lk_big,
   input  logic             fill_en,
   input  logic [19:0]      fill_vpn,
   input  logic [31:0]      fill_pte,
   input  logic             base_wr,
   input  logic             inv_en,
   input  logic [19:0]      inv_vpn
);
   generate
      if (ENTRIES < 2) begin : g_bad_entries
         $error("xlat_cache: ENTRIES must be at least 2");
      end
      if (VPN_W != 20 || PFN_W != 20 || PTE_W != 32) begin : g_bad_widths
         $error("xlat_cache: port widths disagree with package");
      end
   endgenerate

   xlat_ent_t            new_ent;
   xlat_ent_t            ents  [ENTRIES];
   logic [ENTRIES-1:0]   match;
   logic [ENTRIES-1:0]   busy;
   logic [ENTRIES-1:0]   sel;
   logic [ENTRIES-1:0]   valid_v;
   logic [ENTRIES-1:0]   glob_v;

   assign new_ent = decode_pte(fill_vpn, fill_pte);

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      xlat_entry u_ent (
         .clk      (clk),
         .rst_n    (rst_n),
         .lk_vpn   (lk_vpn),
         .flush    (base_wr),
         .inv_en   (inv_en),
         .inv_vpn  (inv_vpn),
         .fill_en  (fill_en),
         .fill_vpn (fill_vpn),
         .fill_big (new_ent.big),
         .wr_sel   (sel[g]),
         .wr_ent   (new_ent),
         .ent      (ents[g]),
         .lk_match (match[g]),
         .busy     (busy[g])
      );
      assign valid_v[g] = ents[g].valid;
      assign glob_v[g]  = ents[g].glob;
   end

   xlat_victim #(.N(ENTRIES)) u_victim (
      .clk     (clk),
      .rst_n   (rst_n),
      .fill_en (fill_en),
      .busy    (busy),
      .sel     (sel)
   );

   xlat_hitmux #(.N(ENTRIES)) u_mux (
      .match  (match),
      .ents   (ents),
      .lk_vpn (lk_vpn),
      .lk_wr  (lk_wr),
      .lk_hit (lk_hit),
      .lk_pfn (lk_pfn),
      .lk_rw  (lk_rw),
      .lk_usr (lk_usr),
      .lk_big (lk_big)
   );

   // R10: no lookup ever sees two matching entries
   a_r10_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));
   // R5: after a flush with no fill, only global entries remain
   a_r5_only_global_left: assert property (@(posedge clk) disable iff (!rst_n)
      (base_wr && !fill_en) |=> ((valid_v & ~glob_v) == '0));
   // R9: a fill is present in the cycle after, whatever maintenance came with it
   a_r9_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> (valid_v != '0));
   // R4: a write lookup never hits without a match
   a_r4_hit_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (match != '0));
endmodule

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] lk_vpn = '0;
   logic        lk_wr = 1'b0;
   logic        lk_hit;
   logic [19:0] lk_pfn;
   logic        lk_rw, lk_usr, lk_big;
   logic        fill_en = 1'b0;
   logic [19:0] fill_vpn = '0;
   logic [31:0] fill_pte = '0;
   logic        base_wr = 1'b0;
   logic        inv_en = 1'b0;
   logic [19:0] inv_vpn = '0;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   xlat_cache #(.ENTRIES(N)) dut_i (.*);

   // ---- bench model ----
   logic        m_valid [N];
   logic [19:0] m_vpn   [N];
   logic [19:0] m_pfn   [N];
   logic        m_rw [N], m_usr [N], m_dirty [N], m_glob [N], m_big [N];
   int          m_rr;

   function automatic logic [31:0] mk(input logic [19:0] fr, input logic rw, input logic usr,
                                      input logic dirty, input logic big, input logic glob);
      return {fr, 3'b000, glob, big, dirty, 1'b0, 2'b00, usr, rw, 1'b1};
   endfunction

   function automatic logic m_cov(input int i, input logic [19:0] v);
      return m_valid[i] && (m_big[i] ? (m_vpn[i][19:10] == v[19:10]) : (m_vpn[i] == v));
   endfunction

   task automatic m_clear();
      for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
      m_rr = 0;
   endtask

   task automatic m_step(input logic fl, input logic iv, input logic [19:0] ivpn,
                         input logic fe, input logic [19:0] fv, input logic [31:0] pte);
      logic keep [N];
      int   slot;
      for (int i = 0; i < N; i++) begin
         keep[i] = m_valid[i];
         if (fl && !m_glob[i]) keep[i] = 1'b0;
         if (iv && m_cov(i, ivpn)) keep[i] = 1'b0;
         if (fe && m_valid[i] && ((m_big[i] || pte[7]) ? (m_vpn[i][19:10] == fv[19:10])
                                                        : (m_vpn[i] == fv))) keep[i] = 1'b0;
      end
      for (int i = 0; i < N; i++) m_valid[i] = keep[i];
      if (fe) begin
         slot = -1;
         for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) slot = i;
         if (slot < 0) begin
            slot = m_rr;
            m_rr = (m_rr + 1) % N;
         end
         m_valid[slot] = 1'b1;   m_vpn[slot] = fv;      m_pfn[slot] = pte[31:12];
         m_rw[slot] = pte[1];    m_usr[slot] = pte[2];  m_dirty[slot] = pte[6];
         m_big[slot] = pte[7];   m_glob[slot] = pte[8];
      end
   endtask

   // ---- check helpers ----
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic op(input logic fl, input logic iv, input logic [19:0] ivpn,
                     input logic fe, input logic [19:0] fv, input logic [31:0] pte);
      @(negedge clk);
      base_wr = fl; inv_en = iv; inv_vpn = ivpn; fill_en = fe; fill_vpn = fv; fill_pte = pte;
      @(posedge clk);
      #1;
      m_step(fl, iv, ivpn, fe, fv, pte);
      base_wr = 1'b0; inv_en = 1'b0; fill_en = 1'b0;
   endtask

   task automatic fill(input logic [19:0] v, input logic [31:0] pte);
      op(1'b0, 1'b0, '0, 1'b1, v, pte);
   endtask

   task automatic look(input string req, input logic [19:0] v, input logic wr,
                       input logic exp_hit, input logic [19:0] exp_pfn);
      @(negedge clk);
      lk_vpn = v; lk_wr = wr;
      #2;
      chk(req, {31'd0, lk_hit}, {31'd0, exp_hit});
      if (exp_hit) chk(req, {12'd0, lk_pfn}, {12'd0, exp_pfn});
   endtask

   task automatic look_model(input logic [19:0] v, input logic wr);
      logic        eh = 1'b0;
      logic [19:0] ep = '0;
      logic        erw = 1'b0, eu = 1'b0, eb = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (m_cov(i, v)) begin
            eh  = !(wr && !m_dirty[i]);
            ep  = m_big[i] ? {m_pfn[i][19:10], v[9:0]} : m_pfn[i];
            erw = m_rw[i]; eu = m_usr[i]; eb = m_big[i];
         end
      end
      @(negedge clk);
      lk_vpn = v; lk_wr = wr;
      #2;
      chk("R10 model hit", {31'd0, lk_hit}, {31'd0, eh});
      if (eh) chk("R2 model fields", {9'd0, lk_pfn, lk_rw, lk_usr, lk_big},
                  {9'd0, ep, erw, eu, eb});
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      m_clear();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic logic [19:0] rvpn();
      return {8'h00, 2'($urandom % 4), 7'h00, 3'($urandom % 8)};
   endfunction

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      logic [19:0] fr;
      void'($urandom(32'd4242));
      do_reset();

      // R1: empty after reset
      look("R1 empty", 20'h00123, 1'b0, 1'b0, '0);
      look("R1 empty", 20'h40000, 1'b1, 1'b0, '0);

      // R2: small page fill and field decode
      fill(20'h00123, mk(20'hABCDE, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0));
      look("R2 small hit", 20'h00123, 1'b0, 1'b1, 20'hABCDE);
      chk("R2 perms", {29'd0, lk_rw, lk_usr, lk_big}, {29'd0, 3'b110});
      // R3: small page needs an exact match
      look("R3 small exact", 20'h00124, 1'b0, 1'b0, '0);

      // R3: large page matches on upper bits, frame merges low bits
      fr = 20'h55500;
      fill(20'h40000, mk(fr, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0));
      look("R3 large hit", 20'h40077, 1'b0, 1'b1, {fr[19:10], 10'h077});
      chk("R3 large flag", {31'd0, lk_big}, 32'd1);
      look("R3 large other", 20'h40477, 1'b0, 1'b0, '0);

      // R4: dirty rule on write lookups
      fill(20'h00200, mk(20'h12345, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
      look("R4 clean write", 20'h00200, 1'b1, 1'b0, '0);
      look("R4 clean read", 20'h00200, 1'b0, 1'b1, 20'h12345);
      look("R4 dirty write", 20'h00123, 1'b1, 1'b1, 20'hABCDE);

      // R5: base write keeps only global entries
      do_reset();
      fill(20'h00300, mk(20'h00AAA, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1));
      fill(20'h00301, mk(20'h00BBB, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0));
      op(1'b1, 1'b0, '0, 1'b0, '0, '0);
      look("R5 global kept", 20'h00300, 1'b0, 1'b1, 20'h00AAA);
      look("R5 local dropped", 20'h00301, 1'b0, 1'b0, '0);

      // R6: single-page invalidate
      fill(20'h00301, mk(20'h00BBB, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0));
      fill(20'h00302, mk(20'h00CCC, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0));
      op(1'b0, 1'b1, 20'h00301, 1'b0, '0, '0);
      look("R6 target gone", 20'h00301, 1'b0, 1'b0, '0);
      look("R6 neighbour kept", 20'h00302, 1'b0, 1'b1, 20'h00CCC);
      look("R6 global kept", 20'h00300, 1'b0, 1'b1, 20'h00AAA);
      op(1'b0, 1'b1, 20'h00300, 1'b0, '0, '0);
      look("R6 global removed", 20'h00300, 1'b0, 1'b0, '0);

      // R9: flush and fill together, fill survives
      op(1'b1, 1'b0, '0, 1'b1, 20'h00310, mk(20'h00DDD, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0));
      look("R9 fill after flush", 20'h00310, 1'b0, 1'b1, 20'h00DDD);
      look("R9 old flushed", 20'h00302, 1'b0, 1'b0, '0);
      op(1'b0, 1'b1, 20'h00310, 1'b1, 20'h00310, mk(20'h00EEE, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0));
      look("R9 fill after inv", 20'h00310, 1'b0, 1'b1, 20'h00EEE);

      // R8: large fill replaces an overlapped small entry
      fill(20'h80005, mk(20'h00001, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0));
      fr = 20'h22000;
      fill(20'h80000, mk(fr, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0));
      look("R8 overlap replaced", 20'h80005, 1'b0, 1'b1, {fr[19:10], 10'h005});
      chk("R8 big flag", {31'd0, lk_big}, 32'd1);

      // R7: round-robin eviction on a full cache
      do_reset();
      for (int i = 0; i < N; i++)
         fill(20'h01000 + 20'(i), mk(20'(i + 16), 1'b1, 1'b0, 1'b1, 1'b0, 1'b0));
      look("R7 all present", 20'h01007, 1'b0, 1'b1, 20'd23);
      fill(20'h02000, mk(20'h00777, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0));
      look("R7 slot0 evicted", 20'h01000, 1'b0, 1'b0, '0);
      look("R7 slot1 kept", 20'h01001, 1'b0, 1'b1, 20'd17);
      fill(20'h02001, mk(20'h00778, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0));
      look("R7 slot1 evicted", 20'h01001, 1'b0, 1'b0, '0);
      look("R7 slot2 kept", 20'h01002, 1'b0, 1'b1, 20'd18);
      look("R7 new kept", 20'h02000, 1'b0, 1'b1, 20'h00777);

      // random mix against the model (R2, R3, R4, R5, R6, R8, R10)
      do_reset();
      for (int k = 0; k < 3000; k++) begin
         op(($urandom % 16) == 0, ($urandom % 6) == 0, rvpn(),
            ($urandom % 3) == 0, rvpn(),
            mk(20'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               ($urandom % 4) == 0, ($urandom % 4) == 0));
         look_model(rvpn(), 1'($urandom));
         look_model(rvpn(), 1'b0);
      end

      done = 1;
      finish_run();
   end
endmodule